// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Character Queue

This block turns an asynchronous serial line into characters for a host. It runs from the system clock. A one-cycle enable arrives sixteen times per bit period. The line is first passed through a synchronizer. A falling edge then starts a frame, and the start bit is checked again half a bit later. A low pulse that has already ended by then is dropped as noise. After that, the receiver takes 5 to 8 data bits, least significant first, and an optional parity bit. The stop position is sampled last.

Every finished character goes into a queue together with three tags of its own: a parity mismatch, a stop bit found low, and a line break. These tags stay with the character until the host pops it. The host sees the oldest entry, a valid flag and the number of stored entries. A pop strobe removes one entry.

A mode input sets the depth. With the queue enabled it holds up to 16 characters. With it disabled the block acts as a single holding register. A character that finds no room is dropped and sets a sticky overrun flag.

Top module: `serial_rx_buffer`

## Requirements
- R1: A bit lasts 16 enable pulses. A low line seen on an enable pulse starts a frame. Each bit is sampled near its middle, and data arrives least significant bit first.
- R2: `char_len` sets the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the chosen length read as zero.
- R3: With `par_en` high, a parity bit follows the data. With `par_odd` low the data bits plus the parity bit must hold an even number of ones; with `par_odd` high, an odd number. On a mismatch the entry's `rd_perr` is 1. With `par_en` low, `rd_perr` is always 0.
- R4: If the line is high again at the middle of the start bit, the receiver goes back to idle. No entry is stored.
- R5: If the stop bit is sampled low, that entry's `rd_ferr` is 1.
- R6: A line that stays low through the stop position, with all data bits and the parity bit also zero, gives exactly one entry: data 0, `rd_brk` 1, `rd_ferr` 1, `rd_perr` 0. No further frame starts until the line has gone high.
- R7: In queue mode (`fifo_en`=1), up to 16 entries are kept in arrival order. `rd_level` gives the number of stored entries and `rd_valid` is high when at least one is stored. A `pop` while `rd_valid` is high removes the oldest entry.
- R8: A character that arrives when there is no room is dropped and stored entries stay unchanged. `overrun` then goes to 1 and stays there until `ovr_clr` is pulsed.
- R9: With `fifo_en`=0, at most one entry is held. Any change of `fifo_en` empties the store.
- R10: After reset, `rd_valid`=0, `rd_level`=0 and `overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| char_len | input | 2 | Data bit count minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| pop | input | 1 | Remove the oldest entry |
| ovr_clr | input | 1 | Clear the overrun flag |
| rd_data | output | 8 | Data of the oldest entry |
| rd_perr | output | 1 | Parity error tag of the oldest entry |
| rd_ferr | output | 1 | Framing error tag of the oldest entry |
| rd_brk | output | 1 | Break tag of the oldest entry |
| rd_valid | output | 1 | At least one entry stored |
| rd_level | output | 5 | Number of stored entries |
| overrun | output | 1 | Sticky flag: a character was dropped |

## Verification
Clean characters are sent at every length with mixed bit patterns. This separates errors in bit order and length masking from the error tags. Frames with good and bad parity are sent under both parity senses, and a frame with a low stop bit follows. Each of these must tag only its own entry. A short low glitch, a long break and a filled queue test the three ways a frame can end without a normal entry being added: the glitch gives nothing, the break gives one entry, and a full store drops the character. Holding-register mode and a mode switch show that the capacity and the flush follow `fifo_en`.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef struct packed {
      logic       brk;
      logic       ferr;
      logic       perr;
      logic [7:0] data;
   } srx_entry_t;

   typedef enum logic [2:0] {
      FR_IDLE,
      FR_START,
      FR_DATA,
      FR_PAR,
      FR_STOP,
      FR_WAITHI
   } fr_state_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL}};
            else if (STAGES == 1) chain[0] <= d;
            else chain <= {chain[STAGES-2:0], d};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/srx_framer.sv
module srx_framer
   import srx_pkg::*;
#(
   parameter int OVERSAMPLE = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rxs,
   input  logic [1:0] char_len,
   input  logic       par_en,
   input  logic       par_odd,
   output logic       push,
   output srx_entry_t push_entry
);

   localparam int SUB_W = $clog2(OVERSAMPLE);
   localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVERSAMPLE / 2 - 1);
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

   fr_state_t        st;
   logic [SUB_W-1:0] sub;
   logic [2:0]       bitn;
   logic [7:0]       shreg;
   logic             pbit;
   logic [2:0]       last_bit;
   logic             stop_zero;

   assign last_bit  = 3'd4 + 3'(char_len);
   assign stop_zero = !rxs && (shreg == 8'd0) && !pbit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= FR_IDLE;
         sub        <= '0;
         bitn       <= '0;
         shreg      <= '0;
         pbit       <= 1'b0;
         push       <= 1'b0;
         push_entry <= '0;
      end else begin
         push <= 1'b0;
         case (st)
            FR_IDLE: begin
               if (tick && !rxs) begin
                  st  <= FR_START;
                  sub <= '0;
               end
            end
            FR_START: begin
               if (tick) begin
                  if (sub == SUB_MID) begin
                     sub   <= '0;
                     bitn  <= '0;
                     shreg <= '0;
                     pbit  <= 1'b0;
                     st    <= rxs ? FR_IDLE : FR_DATA;
                  end else begin
                     sub <= sub + 1'b1;
                  end
               end
            end
            FR_DATA: begin
               if (tick) begin
                  if (sub == SUB_LAST) begin
                     sub         <= '0;
                     shreg[bitn] <= rxs;
                     if (bitn == last_bit) st <= par_en ? FR_PAR : FR_STOP;
                     else bitn <= bitn + 1'b1;
                  end else begin
                     sub <= sub + 1'b1;
                  end
               end
            end
            FR_PAR: begin
               if (tick) begin
                  if (sub == SUB_LAST) begin
                     sub  <= '0;
                     pbit <= rxs;
                     st   <= FR_STOP;
                  end else begin
                     sub <= sub + 1'b1;
                  end
               end
            end
            FR_STOP: begin
               if (tick) begin
                  if (sub == SUB_LAST) begin
                     sub             <= '0;
                     push            <= 1'b1;
                     push_entry.data <= shreg;
                     push_entry.ferr <= !rxs;
                     push_entry.brk  <= stop_zero;
                     push_entry.perr <= !stop_zero && par_en &&
                                        ((^shreg ^ pbit) != par_odd);
                     st              <= stop_zero ? FR_WAITHI : FR_IDLE;
                  end else begin
                     sub <= sub + 1'b1;
                  end
               end
            end
            FR_WAITHI: begin
               if (rxs) st <= FR_IDLE;
            end
            default: st <= FR_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/srx_queue.sv
module srx_queue
   import srx_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       fifo_en,
   input  logic                       push,
   input  srx_entry_t                 push_entry,
   input  logic                       pop,
   input  logic                       ovr_clr,
   output srx_entry_t                 head,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output logic                       overrun
);

   localparam int AW    = $clog2(DEPTH);
   localparam int LVL_W = $clog2(DEPTH + 1);
   localparam logic [LVL_W-1:0] CAP_FIFO = LVL_W'(DEPTH);
   localparam logic [LVL_W-1:0] CAP_HOLD = LVL_W'(1);

   srx_entry_t       mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic             mode_q, flush, accept, take;
   logic [LVL_W-1:0] cap;

   assign cap    = fifo_en ? CAP_FIFO : CAP_HOLD;
   assign flush  = fifo_en != mode_q;
   assign accept = push && (level < cap) && !flush;
   assign take   = pop && (level != '0) && !flush;
   assign head   = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         level   <= '0;
         mode_q  <= 1'b0;
         overrun <= 1'b0;
      end else begin
         mode_q <= fifo_en;
         if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
         end else begin
            if (accept) wr_ptr <= wr_ptr + 1'b1;
            if (take)   rd_ptr <= rd_ptr + 1'b1;
            case ({accept, take})
               2'b10:   level <= level + 1'b1;
               2'b01:   level <= level - 1'b1;
               default: level <= level;
            endcase
         end
         if (push && !accept && !flush) overrun <= 1'b1;
         else if (ovr_clr)              overrun <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (accept) mem[wr_ptr] <= push_entry;
   end

endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer
   import srx_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tick16,
   input  logic                       rxd,
   input  logic                       fifo_en,
   input  logic [1:0]                 char_len,
   input  logic                       par_en,
   input  logic                       par_odd,
   input  logic                       pop,
   input  logic                       ovr_clr,
   output logic [7:0]                 rd_data,
   output logic                       rd_perr,
   output logic                       rd_ferr,
   output logic                       rd_brk,
   output logic                       rd_valid,
   output logic [$clog2(DEPTH+1)-1:0] rd_level,
   output logic                       overrun
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (OVERSAMPLE < 4 || (OVERSAMPLE & (OVERSAMPLE - 1)) != 0) begin : g_bad_os
         $error("OVERSAMPLE must be a power of two of at least 4");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic       rxs;
   logic       push_w;
   srx_entry_t push_entry_w;
   srx_entry_t head_w;

   srx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxs)
   );

   srx_framer #(.OVERSAMPLE(OVERSAMPLE)) framer_i (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .rxs(rxs),
      .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
      .push(push_w), .push_entry(push_entry_w)
   );

   srx_queue #(.DEPTH(DEPTH)) queue_i (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
      .push(push_w), .push_entry(push_entry_w),
      .pop(pop), .ovr_clr(ovr_clr),
      .head(head_w), .level(rd_level), .overrun(overrun)
   );

   assign rd_valid = rd_level != '0;
   assign rd_data  = head_w.data;
   assign rd_perr  = head_w.perr;
   assign rd_ferr  = head_w.ferr;
   assign rd_brk   = head_w.brk;

endmodule

// File: rtl/serial_rx_buffer_chk.sv
module serial_rx_buffer_chk #(
   parameter int DEPTH = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       fifo_en,
   input logic                       pop,
   input logic                       ovr_clr,
   input logic                       push,
   input logic [$clog2(DEPTH+1)-1:0] level,
   input logic                       rd_valid,
   input logic [7:0]                 rd_data,
   input logic                       rd_ferr,
   input logic                       rd_brk,
   input logic                       overrun
);

   a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= ($clog2(DEPTH+1))'(DEPTH));

   a_r7_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
      pop && rd_valid && !push && $stable(fifo_en)
      |=> level == $past(level) - 1'b1);

   a_r9_hold_cap: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |=> (fifo_en || level <= 1));

   a_r6_break_entry: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && rd_brk |-> (rd_data == 8'd0) && rd_ferr);

   a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun && !ovr_clr |=> overrun);

endmodule

bind serial_rx_buffer serial_rx_buffer_chk #(.DEPTH(DEPTH)) chk_i (
   .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .pop(pop),
   .ovr_clr(ovr_clr), .push(push_w), .level(rd_level),
   .rd_valid(rd_valid), .rd_data(rd_data), .rd_ferr(rd_ferr),
   .rd_brk(rd_brk), .overrun(overrun)
);

// File: tb/serial_rx_buffer_tb_top.sv
module serial_rx_buffer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       rxd = 1'b1;
   logic       fifo_en = 1'b1;
   logic [1:0] char_len = 2'd3;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       pop = 1'b0;
   logic       ovr_clr = 1'b0;
   logic [7:0] rd_data;
   logic       rd_perr, rd_ferr, rd_brk, rd_valid, overrun;
   logic [4:0] rd_level;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  drain_en = 1'b0;
   bit  done = 1'b0;
   logic [10:0] exp_q [$];   // {brk, ferr, perr, data}

   always #5 clk = ~clk;
   always @(posedge clk) tick16 <= ~tick16;

   serial_rx_buffer dut_i (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
      .fifo_en(fifo_en), .char_len(char_len), .par_en(par_en),
      .par_odd(par_odd), .pop(pop), .ovr_clr(ovr_clr),
      .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
      .rd_brk(rd_brk), .rd_valid(rd_valid), .rd_level(rd_level),
      .overrun(overrun)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops entries and compares them with the scoreboard
   always @(negedge clk) begin
      if (pop) pop = 1'b0;
      else if (drain_en && rd_valid) begin
         logic [10:0] got;
         got = {rd_brk, rd_ferr, rd_perr, rd_data};
         if (exp_q.size() == 0) chk(1'b0, "R7 unexpected entry", got, 0);
         else begin
            logic [10:0] e;
            e = exp_q.pop_front();
            chk(got == e, "R1/R2/R3/R5/R6/R7 entry", got, e);
         end
         pop = 1'b1;
      end
   end

   task automatic bit_time(input logic v);
      rxd = v;
      repeat (32) @(posedge clk);
      #1;
   endtask

   // driver: sends one frame and records the expected entry
   task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                       input bit expect_it);
      int nb;
      logic [7:0] m;
      logic pb;
      nb = 5 + int'(char_len);
      m  = d & 8'((1 << nb) - 1);
      pb = (^m) ^ par_odd ^ bad_par;
      if (expect_it) exp_q.push_back({1'b0, bad_stop, par_en & bad_par, m});
      bit_time(1'b0);
      for (int i = 0; i < nb; i++) bit_time(d[i]);
      if (par_en) bit_time(pb);
      bit_time(!bad_stop);
      bit_time(1'b1);
      bit_time(1'b1);
   endtask

   task automatic wait_drain(input string req);
      int n;
      n = 0;
      while ((exp_q.size() != 0 || rd_valid) && n < 4000) begin
         @(posedge clk);
         n++;
      end
      repeat (4) @(posedge clk);
      #2;
      chk(exp_q.size() == 0 && rd_level == 0, req, exp_q.size(), 0);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5) @(posedge clk);
      #2;
      // R10 reset state
      chk(!rd_valid && rd_level == 0 && !overrun, "R10 reset", rd_level, 0);
      rst_n = 1'b1;
      repeat (4) @(posedge clk);
      #1;
      drain_en = 1'b1;

      // R1 8-bit characters, LSB first
      send(8'hA5, 0, 0, 1);
      send(8'h3C, 0, 0, 1);
      send(8'h01, 0, 0, 1);
      wait_drain("R1 8-bit stream");

      // R2 shorter lengths
      char_len = 2'd0; send(8'hF5, 0, 0, 1);
      char_len = 2'd1; send(8'hEA, 0, 0, 1);
      char_len = 2'd2; send(8'hD5, 0, 0, 1);
      wait_drain("R2 lengths");

      // R3 parity both senses, good and bad
      par_en = 1'b1;
      par_odd = 1'b0; send(8'h37, 0, 0, 1); send(8'h37, 1, 0, 1);
      par_odd = 1'b1; send(8'h52, 0, 0, 1); send(8'h52, 1, 0, 1);
      wait_drain("R3 parity");
      par_en = 1'b0; char_len = 2'd3;

      // R5 framing error
      send(8'h81, 0, 1, 1);
      send(8'h7E, 0, 0, 1);
      wait_drain("R5 framing");

      // R4 false start: glitch of 3 ticks
      rxd = 1'b0;
      repeat (6) @(posedge clk);
      #1;
      bit_time(1'b1); bit_time(1'b1); bit_time(1'b1);
      chk(rd_level == 0 && !rd_valid, "R4 false start stored nothing", rd_level, 0);
      send(8'h5A, 0, 0, 1);
      wait_drain("R4 after false start");

      // R6 break: long low, one entry, then normal reception
      exp_q.push_back({1'b1, 1'b1, 1'b0, 8'h00});
      for (int i = 0; i < 15; i++) bit_time(1'b0);
      bit_time(1'b1); bit_time(1'b1);
      wait_drain("R6 break single entry");
      send(8'hC3, 0, 0, 1);
      wait_drain("R6 after break");

      // R7/R8 fill the queue and overflow
      drain_en = 1'b0;
      for (int i = 0; i < 17; i++) send(8'(i * 7 + 1), 0, 0, i < 16);
      #2;
      chk(rd_level == 16, "R7 level full", rd_level, 16);
      chk(overrun, "R8 overrun set", overrun, 1);
      drain_en = 1'b1;
      wait_drain("R7 order after fill");
      chk(overrun, "R8 overrun sticky", overrun, 1);
      @(negedge clk); ovr_clr = 1'b1;
      @(negedge clk); ovr_clr = 1'b0;
      chk(!overrun, "R8 overrun cleared", overrun, 0);

      // R9 holding-register mode
      drain_en = 1'b0;
      @(negedge clk); fifo_en = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      send(8'h11, 0, 0, 1);
      send(8'h22, 0, 0, 0);
      #2;
      chk(rd_level == 1, "R9 hold capacity", rd_level, 1);
      chk(overrun, "R9 hold overrun", overrun, 1);
      drain_en = 1'b1;
      wait_drain("R9 hold keeps first");
      @(negedge clk); ovr_clr = 1'b1;
      @(negedge clk); ovr_clr = 1'b0;

      // R9 mode change flushes
      drain_en = 1'b0;
      @(negedge clk); fifo_en = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      send(8'h44, 0, 0, 0);
      send(8'h55, 0, 0, 0);
      #2;
      chk(rd_level == 2, "R9 queue mode stores two", rd_level, 2);
      @(negedge clk); fifo_en = 1'b0;
      repeat (2) @(negedge clk);
      chk(rd_level == 0 && !rd_valid, "R9 flush on mode change", rd_level, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule